// File: doc/BRIEF.md
# Embedded Controller Program Download Port

This block is the loading path for the code memory of a small embedded 8-bit controller. A host writes single 32-bit words to one register. Each word carries a control code, one data byte and a byte address. While the control code selects upload, every write stores its byte into the code RAM and holds the controller in reset.

The same register is read back to check the image. A read returns the current code, the RAM byte at the current pointer and the pointer itself. A read in upload mode also advances the pointer, so repeated reads walk through the whole image. After the image is written, the host writes a "loaded" code and then, once the readback matches, a "verified" code. Only the verified code releases the controller from reset.

The address field is 14 bits wide. The RAM depth is a parameter (2048 bytes by default) and is indexed by the low address bits, so larger addresses alias. The read data is combinational from the current state: it shows the register contents before any strobe in the same cycle takes effect.

Top module: `prog_dl_port`

## Requirements
- R1: After reset the read word shows code 0x00 in bits 31:24 and pointer 0 in bits 13:0, and core_rst_o is 1.
- R2: A write whose code (bits 31:24) is 0x0F stores bits 23:16 into the code RAM at the low RAM_AW bits of the address field (bits 13:0).
- R3: Every write loads its code into the code register and its bits 13:0 into the pointer. Bits 15:14 of the write word have no effect.
- R4: The read word is {code, RAM byte at pointer, 2'b00, pointer}. The fields are bits 31:24, 23:16, 15:14 and 13:0.
- R5: A read strobe without a write, while the code is 0x0F, advances the pointer by one after that cycle. The pointer wraps from 0x3FFF to 0x0000.
- R6: A read strobe while the code is not 0x0F leaves the pointer unchanged.
- R7: A write with any code other than 0x0F leaves the code RAM unchanged.
- R8: core_rst_o is 0 only while the most recent write carried code 0x13 (verified). Codes 0x0F, 0x03 and any other code hold it at 1.
- R9: When a write and a read strobe fall in the same cycle, that cycle's read word shows the state before the write. The write then takes effect with no increment, so the next word shows the written address and byte.
- R10: In upload mode, a read right after a write returns exactly the written code, byte and address, with bits 15:14 zero. This lets the host tell an upper-address error (bits 13:8) from a low-byte error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Host write strobe |
| rd_i | input | 1 | Host read strobe (advances pointer in upload mode) |
| wdata_i | input | 32 | Write word: code, data byte, address |
| rdata_o | output | 32 | Read word: code, RAM byte at pointer, pointer |
| core_rst_o | output | 1 | Reset to the embedded controller, active high |

## Verification
Two functions can fall in the same cycle: a host write and a read-advance. The bench provokes this directly and also through random strobes that often coincide. It then checks that the word sampled in that cycle still shows the old pointer and byte. It also checks that the following word shows the written address and byte, not that address plus one. A write with a non-upload code aimed at an address that already holds a byte shows the same priority from the other side: the pointer moves, but the byte read back must stay the old one.

// File: rtl/prog_dl_pkg.sv
package prog_dl_pkg;
  localparam int FIELD_AW = 14;
  localparam logic [7:0] CODE_IDLE   = 8'h00;
  localparam logic [7:0] CODE_UPLOAD = 8'h0F;
  localparam logic [7:0] CODE_LOADED = 8'h03;
  localparam logic [7:0] CODE_VERIFY = 8'h13;

  typedef struct packed {
    logic [7:0]          code;
    logic [7:0]          data;
    logic [1:0]          pad;
    logic [FIELD_AW-1:0] addr;
  } dl_word_t;
endpackage

// File: rtl/dl_code_ram.sv
module dl_code_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dl_ptr.sv
module dl_ptr #(
  parameter int AW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic          step_i,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0] ptr_q;

  // load has priority over step; step wraps naturally at 2**AW
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (load_i) ptr_q <= load_addr_i;
    else if (step_i) ptr_q <= ptr_q + AW'(1);
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/dl_ctrl.sv
module dl_ctrl
  import prog_dl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] code_i,
  output logic [7:0] code_o,
  output logic       upload_o,
  output logic       core_rst_o
);
  logic [7:0] code_q;
  logic       run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= CODE_IDLE;
      run_q  <= 1'b0;
    end else if (wr_i) begin
      code_q <= code_i;
      run_q  <= (code_i == CODE_VERIFY);
    end
  end

  assign code_o     = code_q;
  assign upload_o   = (code_q == CODE_UPLOAD);
  assign core_rst_o = ~run_q;
endmodule

// File: rtl/prog_dl_port.sv
module prog_dl_port
  import prog_dl_pkg::*;
#(
  parameter int RAM_AW = 11
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        core_rst_o
);
  dl_word_t            w_in;
  logic [7:0]          code_q;
  logic                upload;
  logic [FIELD_AW-1:0] ptr;
  logic [RAM_AW-1:0]   ram_waddr;
  logic [RAM_AW-1:0]   ram_raddr;
  logic [7:0]          ram_byte;
  logic                ram_we;
  logic                step;

  assign w_in = dl_word_t'(wdata_i);

  generate
    if (RAM_AW > FIELD_AW) begin : g_bad_depth
      initial $error("RAM_AW exceeds address field width");
    end
  endgenerate

  dl_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i),
    .code_i     (w_in.code),
    .code_o     (code_q),
    .upload_o   (upload),
    .core_rst_o (core_rst_o)
  );

  assign step = rd_i & ~wr_i & upload;

  dl_ptr #(.AW(FIELD_AW)) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (wr_i),
    .load_addr_i (w_in.addr),
    .step_i      (step),
    .ptr_o       (ptr)
  );

  assign ram_we    = wr_i & (w_in.code == CODE_UPLOAD);
  assign ram_waddr = w_in.addr[RAM_AW-1:0];
  assign ram_raddr = ptr[RAM_AW-1:0];

  dl_code_ram #(.AW(RAM_AW), .DW(8)) u_ram (
    .clk_i   (clk_i),
    .we_i    (ram_we),
    .waddr_i (ram_waddr),
    .wdata_i (w_in.data),
    .raddr_i (ram_raddr),
    .rdata_o (ram_byte)
  );

  assign rdata_o = {code_q, ram_byte, 2'b00, ptr};
endmodule

// File: rtl/prog_dl_port_chk.sv
module prog_dl_port_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_i,
  input logic        rd_i,
  input logic [31:0] wdata_i,
  input logic [31:0] rdata_o,
  input logic        core_rst_o
);
  a_r2_store_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[31:24] == 8'h0F) |=> rdata_o[23:16] == $past(wdata_i[23:16]));

  a_r3_load_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (rdata_o[13:0] == $past(wdata_i[13:0]) && rdata_o[31:24] == $past(wdata_i[31:24])));

  a_r4_pad_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[15:14] == 2'b00);

  a_r5_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && rdata_o[31:24] == 8'h0F) |=> rdata_o[13:0] == $past(rdata_o[13:0]) + 14'd1);

  a_r6_hold_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && rdata_o[31:24] != 8'h0F) |=> $stable(rdata_o[13:0]));

  a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[31:24] == 8'h13) |=> !core_rst_o);

  a_r8_hold_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[31:24] != 8'h13) |=> core_rst_o);

  a_r8_stable_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(core_rst_o));
endmodule

bind prog_dl_port prog_dl_port_chk u_chk (.*);

// File: tb/sim_prog_dl_port.sv
module sim_prog_dl_port;
  localparam int RAM_AW = 11;
  localparam int DEPTH  = 1 << RAM_AW;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        core_rst_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  logic [7:0]  m_mem [DEPTH];
  bit          m_val [DEPTH];
  logic [7:0]  m_code = 8'h00;
  logic [13:0] m_ptr = '0;
  bit          m_run = 1'b0;

  prog_dl_port #(.RAM_AW(RAM_AW)) u0 (.*);

  always #5 clk_i = ~clk_i;

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      finish_run();
    end
  end

  function automatic logic [31:0] exp_word();
    logic [RAM_AW-1:0] i = m_ptr[RAM_AW-1:0];
    return {m_code, m_val[i] ? m_mem[i] : 8'h00, 2'b00, m_ptr};
  endfunction

  function automatic logic [31:0] mk(logic [7:0] c, logic [7:0] d, logic [13:0] a);
    return {c, d, 2'($urandom_range(0, 3)), a};
  endfunction

  task automatic check(string tag);
    logic [31:0] e = exp_word();
    logic [31:0] m = m_val[m_ptr[RAM_AW-1:0]] ? 32'hFFFF_FFFF : 32'hFF00_FFFF;
    n_chk++;
    if (((rdata_o & m) !== e) || (core_rst_o !== !m_run)) begin
      n_fail++;
      $display("FAIL %s: actual %h/%b expected %h/%b", tag, rdata_o & m, core_rst_o, e, !m_run);
    end
  endtask

  // one host cycle: drive at negedge, check pre-edge word, update model after edge
  task automatic step(bit w, bit r, logic [31:0] d, string tag);
    @(negedge clk_i);
    wr_i = w; rd_i = r; wdata_i = d;
    #1 check(tag);
    @(posedge clk_i);
    if (w) begin
      m_code = d[31:24];
      m_ptr  = d[13:0];
      m_run  = (d[31:24] == 8'h13);
      if (d[31:24] == 8'h0F) begin
        m_mem[d[RAM_AW-1:0]] = d[23:16];
        m_val[d[RAM_AW-1:0]] = 1'b1;
      end
    end else if (r && m_code == 8'h0F) begin
      m_ptr = m_ptr + 14'd1;
    end
    @(negedge clk_i);
    wr_i = 1'b0; rd_i = 1'b0;
  endtask

  initial begin
    logic [7:0] codes [4];
    codes = '{8'h0F, 8'h03, 8'h13, 8'h5A};
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) m_val[i] = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1 check("R1 reset state");

    // R2 R3 fill whole RAM, random pad bits
    for (int a = 0; a < DEPTH; a++)
      step(1, 0, mk(8'h0F, 8'($urandom), 14'(a)), "R2 R3 fill");
    // R4 R5 R10 readback walk
    step(1, 0, mk(8'h0F, m_mem[0], 14'd0), "R10 rewrite 0");
    for (int a = 0; a < DEPTH + 2; a++) step(0, 1, '0, "R4 R5 walk");
    // R5 wrap
    step(1, 0, mk(8'h0F, 8'hC3, 14'h3FFF), "R5 set top");
    step(0, 1, '0, "R5 top word");
    step(0, 1, '0, "R5 wrapped to 0");
    step(0, 0, '0, "R5 after wrap");
    // R6 R7 R8 loaded code: no advance, no store
    step(1, 0, {8'h03, 8'hAA, 2'b11, 14'd5}, "R7 loaded write");
    step(0, 1, '0, "R6 R7 R8 ptr held byte kept");
    step(0, 1, '0, "R6 still held");
    step(1, 0, {8'h13, 8'h55, 2'b00, 14'd5}, "R8 verify write");
    step(0, 0, '0, "R8 core released R7");
    step(1, 0, {8'h0F, 8'h11, 2'b00, 14'd6}, "R8 back to upload");
    step(0, 0, '0, "R8 held again");
    // R9 write and read together
    step(0, 1, '0, "R9 setup advance");
    step(1, 1, {8'h0F, 8'h9E, 2'b10, 14'd40}, "R9 pre-write word");
    step(0, 0, '0, "R9 written addr no increment");
    step(1, 1, {8'h03, 8'h77, 2'b00, 14'd40}, "R9 R7 same-cycle loaded");
    step(0, 0, '0, "R9 R7 byte kept");

    // random mix
    for (int k = 0; k < 3000; k++) begin
      bit w = ($urandom_range(0, 3) == 0);
      bit r = ($urandom_range(0, 1) == 0);
      logic [7:0] c = ($urandom_range(0, 9) < 7) ? 8'h0F : codes[$urandom_range(1, 3)];
      logic [13:0] a = ($urandom_range(0, 3) == 0) ? 14'($urandom) : 14'($urandom_range(0, DEPTH - 1));
      step(w, r, mk(c, 8'($urandom), a), "R2 R3 R5 R8 R9 random");
    end
    step(0, 0, '0, "R4 final");
    finish_run();
  end
endmodule